// File: doc/BRIEF.md
# Video Configuration Command Stream Decoder

This block sits behind a byte-wide command channel and turns a stream of register-write commands into a bank of 8-bit video configuration registers. Each write command takes four bytes: a start marker, an opcode, a register address and a data byte. Decoded writes land in a shadow bank. The values the display timing logic sees, held in an active bank, change only when a gate-open command arrives. On that command the whole shadow bank is copied across in one step, so a mode change is never seen half-applied.

The active bank is presented as decoded fields: a colour depth select, two 24-bit frame base addresses, twelve 16-bit timing words, a pixel clock word in units of 5 kHz and a sync control byte. Multi-byte fields do not all use the same byte order. The frame bases and timing words keep their most significant byte at the lower address. The pixel clock word keeps its least significant byte at the lower address. Bytes that do not form a valid write command are discarded, and the parser then waits for the next start marker.

Top module: `vcfg_stream_decoder`

## Requirements
- R1: After a synchronous active-low reset, every field output is zero. All shadow and active registers are cleared and the parser waits for a start byte.
- R2: The byte sequence 0xAF, 0x20, address, data writes data into the shadow register at that address. No field output changes until a commit.
- R3: A write of 0xFF to address 0xFF commits. All active registers take the shadow values one clock after the edge that accepts the data byte, and not before.
- R4: A write to address 0xFF with any data other than 0xFF, including the lock value 0x00, changes no shadow or active register.
- R5: While waiting for a start byte, any byte other than 0xAF is dropped. A later well-formed command is still decoded correctly.
- R6: If the byte after 0xAF is not 0x20, the command is dropped and the parser goes back to waiting for 0xAF. The bytes that follow are not taken as address or data.
- R7: depth_sel_o is bit 0 of register 0x00, where 0 selects 16 bpp and 1 selects 24 bpp. The other bits of that register have no effect.
- R8: base16_o is {reg 0x20, reg 0x21, reg 0x22} and base8_o is {reg 0x26, reg 0x27, reg 0x28}, most significant byte first.
- R9: Timing word k (k = 0..11) is {reg 2k+1, reg 2k+2}, with the high byte at the lower address.
- R10: pix_clk_o is {reg 0x1C, reg 0x1B}, with the low byte at the lower address.
- R11: sync_ctl_o is the full byte of register 0x1F. The values 0x00 (both syncs on), 0x01 (blanked, powered) and 0x07 (powerdown) pass through unchanged.
- R12: Writes to an address from 0x30 to 0xFE have no effect, even after a commit.
- R13: in_ready_o is always 1. A byte presented with in_valid_i low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data_i | input | 8 | Command stream byte |
| in_valid_i | input | 1 | Byte qualifier |
| in_ready_o | output | 1 | Byte accept, always high |
| depth_sel_o | output | 1 | 0 = 16 bpp, 1 = 24 bpp |
| base16_o | output | 24 | Base address of the 16-bpp frame |
| base8_o | output | 24 | Base address of the 8-bpp low-bit frame |
| timing_o | output | 192 | Twelve 16-bit timing words, word k in bits 16k+15:16k |
| pix_clk_o | output | 16 | Pixel clock word, 5 kHz units |
| sync_ctl_o | output | 8 | Sync control byte |

## Verification
The stream is driven with several kinds of input: clean back-to-back writes, writes split by idle cycles that carry a start byte with valid low, junk bytes before a command, a command with a bad opcode, and writes to out-of-range addresses. Each kind separates one parser path from the others. A full mode load with distinct bytes at every field address shows whether each field has the right byte order and address. Sampling the outputs on the exact cycle before a commit and the cycle after it separates a correct shadow-then-commit design from one that updates early or late. A behavioural model compares every field on every cycle.

// File: rtl/vcfg_pkg.sv
// Package: shared constants and types for the video configuration decoder.
// Assumes 8-bit register addresses and data.
package vcfg_pkg;
    localparam logic [7:0] START_BYTE = 8'hAF;
    localparam logic [7:0] OP_WRITE   = 8'h20;
    localparam logic [7:0] GATE_ADDR  = 8'hFF;
    localparam logic [7:0] GATE_OPEN  = 8'hFF;

    localparam int A_DEPTH  = 8'h00;
    localparam int A_TIME0  = 8'h01;
    localparam int A_PCLK   = 8'h1B;
    localparam int A_SYNC   = 8'h1F;
    localparam int A_BASE16 = 8'h20;
    localparam int A_BASE8  = 8'h26;

    typedef enum logic [1:0] {
        PS_HUNT,
        PS_OPCODE,
        PS_ADDR,
        PS_DATA
    } pstate_t;

    typedef struct packed {
        logic       en;
        logic [7:0] addr;
        logic [7:0] data;
    } wr_req_t;
endpackage

// File: rtl/vcfg_cmd_parser.sv
// Module: vcfg_cmd_parser
// Frames the byte stream into register writes. It emits a one-cycle
// registered write request after it accepts the data byte of a
// well-formed command. Assumes one byte per valid cycle and no back-pressure.
module vcfg_cmd_parser
    import vcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data_i,
    input  logic       in_valid_i,
    output wr_req_t    wr_o
);
    pstate_t    state_q;
    logic [7:0] addr_q;

    // Command framing state machine; bad bytes fall back to hunting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_HUNT;
        end else if (in_valid_i) begin
            case (state_q)
                PS_HUNT:   state_q <= (in_data_i == START_BYTE) ? PS_OPCODE : PS_HUNT;
                PS_OPCODE: state_q <= (in_data_i == OP_WRITE) ? PS_ADDR : PS_HUNT;
                PS_ADDR:   state_q <= PS_DATA;
                default:   state_q <= PS_HUNT;
            endcase
        end
    end

    // Capture the register address byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (in_valid_i && state_q == PS_ADDR) begin
            addr_q <= in_data_i;
        end
    end

    // Issue the write request after the data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_o <= '0;
        end else begin
            wr_o.en   <= in_valid_i && (state_q == PS_DATA);
            wr_o.addr <= addr_q;
            wr_o.data <= in_data_i;
        end
    end

    AST_HUNT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_HUNT && in_valid_i && in_data_i != START_BYTE) |=> state_q == PS_HUNT); // R5
    AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_OPCODE && in_valid_i && in_data_i != OP_WRITE) |=> (state_q == PS_HUNT && !wr_o.en)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> ($stable(state_q) && !wr_o.en)); // R13
    AST_WR_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o.en |-> $past(state_q == PS_DATA)); // R2
endmodule

// File: rtl/vcfg_reg_bank.sv
// Module: vcfg_reg_bank
// Holds the shadow and active register banks. Writes update only the
// shadow bank. A gate-open write copies the whole shadow bank to the
// active bank in one edge. Assumes REG_COUNT <= 255 so 0xFF is never a
// register address.
module vcfg_reg_bank
    import vcfg_pkg::*;
#(
    parameter int REG_COUNT = 48
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  wr_req_t                     wr_i,
    output logic [REG_COUNT-1:0][7:0]   active_o
);
    logic [REG_COUNT-1:0][7:0] shadow_q;
    logic                      commit;

    assign commit = wr_i.en && (wr_i.addr == GATE_ADDR) && (wr_i.data == GATE_OPEN);

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_shadow
        // Update one shadow byte when its address is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q[g] <= '0;
            end else if (wr_i.en && wr_i.addr == 8'(g)) begin
                shadow_q[g] <= wr_i.data;
            end
        end
    end

    // Copy the whole shadow bank to the active bank on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= '0;
        end else if (commit) begin
            active_o <= shadow_q;
        end
    end

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(active_o)); // R2
    AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> active_o == $past(shadow_q)); // R3
    AST_GATE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i.en && wr_i.addr == GATE_ADDR && wr_i.data != GATE_OPEN) |=> ($stable(shadow_q) && $stable(active_o))); // R4
    AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i.en && wr_i.addr >= 8'(REG_COUNT)) |=> $stable(shadow_q)); // R12
endmodule

// File: rtl/vcfg_field_map.sv
// Module: vcfg_field_map
// Decodes the active bank into named fields, each with its own byte
// order. Purely combinational. Assumes REG_COUNT covers every field address.
module vcfg_field_map
    import vcfg_pkg::*;
#(
    parameter int REG_COUNT = 48,
    parameter int TW_COUNT  = 12
) (
    input  logic [REG_COUNT-1:0][7:0] bank_i,
    output logic                      depth_sel_o,
    output logic [23:0]               base16_o,
    output logic [23:0]               base8_o,
    output logic [TW_COUNT-1:0][15:0] timing_o,
    output logic [15:0]               pix_clk_o,
    output logic [7:0]                sync_ctl_o
);
    // Single-byte and 24-bit fields, high byte at the lowest address.
    always_comb begin
        depth_sel_o = bank_i[A_DEPTH][0];
        base16_o    = {bank_i[A_BASE16], bank_i[A_BASE16+1], bank_i[A_BASE16+2]};
        base8_o     = {bank_i[A_BASE8],  bank_i[A_BASE8+1],  bank_i[A_BASE8+2]};
        pix_clk_o   = {bank_i[A_PCLK+1], bank_i[A_PCLK]};
        sync_ctl_o  = bank_i[A_SYNC];
    end

    for (genvar k = 0; k < TW_COUNT; k++) begin : g_tw
        // Timing word k, high byte at the lower address.
        assign timing_o[k] = {bank_i[A_TIME0 + 2*k], bank_i[A_TIME0 + 2*k + 1]};
    end
endmodule

// File: rtl/vcfg_stream_decoder.sv
// Module: vcfg_stream_decoder
// Top level: command parser, then shadow/active register bank, then
// field decode. Always ready; one byte is taken per valid cycle.
module vcfg_stream_decoder
    import vcfg_pkg::*;
#(
    parameter int REG_COUNT = 48,
    parameter int TW_COUNT  = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [7:0]                  in_data_i,
    input  logic                        in_valid_i,
    output logic                        in_ready_o,
    output logic                        depth_sel_o,
    output logic [23:0]                 base16_o,
    output logic [23:0]                 base8_o,
    output logic [TW_COUNT*16-1:0]      timing_o,
    output logic [15:0]                 pix_clk_o,
    output logic [7:0]                  sync_ctl_o
);
    wr_req_t                   wr;
    logic [REG_COUNT-1:0][7:0] active;
    logic [TW_COUNT-1:0][15:0] tw;

    assign in_ready_o = 1'b1;
    assign timing_o   = tw;

    vcfg_cmd_parser u_parse (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_data_i  (in_data_i),
        .in_valid_i (in_valid_i),
        .wr_o       (wr)
    );

    vcfg_reg_bank #(.REG_COUNT(REG_COUNT)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr),
        .active_o (active)
    );

    vcfg_field_map #(.REG_COUNT(REG_COUNT), .TW_COUNT(TW_COUNT)) u_map (
        .bank_i      (active),
        .depth_sel_o (depth_sel_o),
        .base16_o    (base16_o),
        .base8_o     (base8_o),
        .timing_o    (tw),
        .pix_clk_o   (pix_clk_o),
        .sync_ctl_o  (sync_ctl_o)
    );
endmodule

// File: tb/sim_vcfg_stream_decoder.sv
// Bench: behavioural model of the command stream, compared on every
// clock, plus directed checks at the exact commit cycles.
module sim_vcfg_stream_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 48;
    localparam int NTW        = 12;
    localparam int WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   in_data = 8'h00;
    logic         in_valid = 1'b0;
    logic         in_ready, depth_sel;
    logic [23:0]  base16, base8;
    logic [NTW*16-1:0] timing;
    logic [15:0]  pix_clk;
    logic [7:0]   sync_ctl;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // Model state
    logic [7:0] m_shadow [NREG];
    logic [7:0] m_active [NREG];
    int         m_st = 0;
    logic [7:0] m_addr = 8'h00;
    bit         m_pend = 1'b0;
    logic [7:0] m_pa = 8'h00, m_pd = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    vcfg_stream_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_data_i(in_data), .in_valid_i(in_valid),
        .in_ready_o(in_ready), .depth_sel_o(depth_sel), .base16_o(base16),
        .base8_o(base8), .timing_o(timing), .pix_clk_o(pix_clk), .sync_ctl_o(sync_ctl)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference model: pending write applies first, then the new byte is parsed.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                m_shadow[i] = 8'h00;
                m_active[i] = 8'h00;
            end
            m_st = 0; m_pend = 1'b0;
        end else begin
            if (m_pend) begin
                if (m_pa == 8'hFF) begin
                    if (m_pd == 8'hFF)
                        for (int i = 0; i < NREG; i++) m_active[i] = m_shadow[i];
                end else if (int'(m_pa) < NREG) begin
                    m_shadow[m_pa] = m_pd;
                end
            end
            m_pend = 1'b0;
            if (in_valid) begin
                case (m_st)
                    0: m_st = (in_data == 8'hAF) ? 1 : 0;
                    1: m_st = (in_data == 8'h20) ? 2 : 0;
                    2: begin m_addr = in_data; m_st = 3; end
                    default: begin m_pend = 1'b1; m_pa = m_addr; m_pd = in_data; m_st = 0; end
                endcase
            end
        end
    end

    // Per-cycle comparison of every field against the model.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk(depth_sel == m_active[0][0], "R7", "depth", 32'(depth_sel), 32'(m_active[0][0]));
            chk(base16 == {m_active[8'h20], m_active[8'h21], m_active[8'h22]}, "R8", "base16",
                32'(base16), 32'({m_active[8'h20], m_active[8'h21], m_active[8'h22]}));
            chk(base8 == {m_active[8'h26], m_active[8'h27], m_active[8'h28]}, "R8", "base8",
                32'(base8), 32'({m_active[8'h26], m_active[8'h27], m_active[8'h28]}));
            for (int k = 0; k < NTW; k++)
                chk(timing[16*k +: 16] == {m_active[2*k+1], m_active[2*k+2]}, "R9", "timing word",
                    32'(timing[16*k +: 16]), 32'({m_active[2*k+1], m_active[2*k+2]}));
            chk(pix_clk == {m_active[8'h1C], m_active[8'h1B]}, "R10", "pix_clk",
                32'(pix_clk), 32'({m_active[8'h1C], m_active[8'h1B]}));
            chk(sync_ctl == m_active[8'h1F], "R11", "sync", 32'(sync_ctl), 32'(m_active[8'h1F]));
            chk(in_ready == 1'b1, "R13", "ready", 32'(in_ready), 32'd1);
        end
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic send(input logic [7:0] b);
        in_valid = 1'b1; in_data = b;
        @(negedge clk);
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0; in_data = 8'hAF;
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        send(8'hAF); send(8'h20); send(a); send(d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({depth_sel, base16, base8, pix_clk, sync_ctl} == '0 && timing == '0, "R1", "reset",
            32'(base16), 32'd0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);

        // R2: shadow writes are not visible before commit
        wr(8'h20, 8'h12); wr(8'h21, 8'h34); wr(8'h22, 8'h56);
        quiet(3);
        chk(base16 == 24'h0, "R2", "base16 before commit", 32'(base16), 32'h0);
        // R4: lock write changes nothing
        wr(8'hFF, 8'h00);
        quiet(2);
        chk(base16 == 24'h0, "R4", "base16 after lock", 32'(base16), 32'h0);
        // R3: exact commit cycle
        wr(8'hFF, 8'hFF);
        chk(base16 == 24'h0, "R3", "base16 one cycle early", 32'(base16), 32'h0);
        quiet(1);
        chk(base16 == 24'h123456, "R3", "base16 after commit", 32'(base16), 32'h123456);

        // Full mode load, back to back
        wr(8'hFF, 8'h00);
        wr(8'h00, 8'h01);
        wr(8'h26, 8'h09); wr(8'h27, 8'h60); wr(8'h28, 8'h00);
        wr(8'h01, 8'hA1); wr(8'h02, 8'hB2);
        wr(8'h17, 8'h02); wr(8'h18, 8'h58);
        wr(8'h1B, 8'h34); wr(8'h1C, 8'h12);
        wr(8'h1F, 8'h07);
        wr(8'hFF, 8'hFF);
        quiet(1);
        chk(depth_sel == 1'b1, "R7", "depth 24bpp", 32'(depth_sel), 32'd1);
        chk(base8 == 24'h096000, "R8", "base8", 32'(base8), 32'h096000);
        chk(timing[15:0] == 16'hA1B2, "R9", "timing word 0", 32'(timing[15:0]), 32'hA1B2);
        chk(timing[191:176] == 16'h0258, "R9", "timing word 11", 32'(timing[191:176]), 32'h0258);
        chk(pix_clk == 16'h1234, "R10", "pix_clk", 32'(pix_clk), 32'h1234);
        chk(sync_ctl == 8'h07, "R11", "sync powerdown", 32'(sync_ctl), 32'h07);

        // R5: junk before a command
        send(8'h55); send(8'h20); send(8'h1F); send(8'h02);
        wr(8'h1F, 8'h01); wr(8'hFF, 8'hFF);
        quiet(1);
        chk(sync_ctl == 8'h01, "R5", "sync after junk", 32'(sync_ctl), 32'h01);
        // R6: bad opcode drops the command
        send(8'hAF); send(8'h21); send(8'h1F); send(8'h00);
        wr(8'hFF, 8'hFF);
        quiet(1);
        chk(sync_ctl == 8'h01, "R6", "sync after bad opcode", 32'(sync_ctl), 32'h01);

        // R12: out-of-range addresses that alias low bits
        wr(8'h5F, 8'h00); wr(8'h40, 8'h00); wr(8'h30, 8'h00);
        wr(8'hFF, 8'hFF);
        quiet(1);
        chk(sync_ctl == 8'h01, "R12", "sync after 0x5F", 32'(sync_ctl), 32'h01);
        chk(depth_sel == 1'b1, "R12", "depth after 0x40", 32'(depth_sel), 32'd1);

        // R4: non-open data to the gate address does not commit
        wr(8'h1F, 8'h00); wr(8'hFF, 8'h12);
        quiet(2);
        chk(sync_ctl == 8'h01, "R4", "sync after 0xFF=0x12", 32'(sync_ctl), 32'h01);
        wr(8'hFF, 8'hFF);
        quiet(1);
        chk(sync_ctl == 8'h00, "R11", "sync on", 32'(sync_ctl), 32'h00);

        // R7: only bit 0 selects depth
        wr(8'h00, 8'hFE); wr(8'hFF, 8'hFF);
        quiet(1);
        chk(depth_sel == 1'b0, "R7", "depth 0xFE", 32'(depth_sel), 32'd0);

        // R13: invalid cycles with a start byte on the bus are ignored
        send(8'hAF); quiet(2); send(8'h20); quiet(1); send(8'h1F); quiet(3); send(8'h07);
        quiet(1);
        wr(8'hFF, 8'hFF);
        quiet(1);
        chk(sync_ctl == 8'h07, "R13", "sync with gaps", 32'(sync_ctl), 32'h07);

        // R1: reset in the middle of a stream
        send(8'hAF); send(8'h20);
        cmp_on = 1'b0;
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        chk({depth_sel, base16, base8, pix_clk, sync_ctl} == '0 && timing == '0, "R1", "mid reset",
            32'(sync_ctl), 32'd0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        send(8'h1F); send(8'h07); wr(8'hFF, 8'hFF);
        quiet(1);
        chk(sync_ctl == 8'h00, "R1", "parser cleared by reset", 32'(sync_ctl), 32'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule